// File: doc/BRIEF.md
# Per-Slot Bidirectional Serial Port Driver

This block drives a single bidirectional serial data line that is divided into byte-wide time slots. An external frame counter supplies the current slot number and bit number, together with two strobes: one marks the edge on which a new bit is presented, the other marks the opposite edge on which the line is sampled. Every slot has its own direction, assignment and idle behaviour. An input slot releases the line and collects eight sampled bits into a per-slot receive buffer. An output slot either shifts out a byte supplied through the transmit stream, or, when nothing is assigned or nothing is waiting, sends a per-slot idle byte or floats the line.

Two global controls act on the pin only. The first selects push-pull tristate signalling or open-drain signalling, where a 1 is produced by releasing the line to an external pull-up. The second is a standby control that floats the pin at once, while transmit bytes are still consumed and input slots are still received.

Transmit bytes enter through a valid/ready stream that carries a slot number. Each slot has a one-byte holding register. `tx_ready` reports whether the holding register of the slot on `tx_slot` is empty. A byte is accepted on a cycle where `tx_valid` and `tx_ready` are both high, and it stays there until the start of that slot. Received bytes leave through a valid/ready stream. When several slots hold data, the lowest-numbered slot is presented first. The upstream side cannot be stalled by the line, so a slot that receives a new byte before the old one is taken overwrites it with the newer byte. The presented data for a waiting slot can therefore change while `rx_valid` stays high.

Top module: `sdp_slot_port`

## Requirements
- R1: After reset, `sd_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1 for every slot. The preset configuration makes the lower half of the slots (0 to NSLOT/2-1) unassigned floating outputs and the upper half inputs.
- R2: An assigned output slot whose holding register is full sends that byte MSB first. Bit number b (0 = first) is sent on the `tx_stb` for that slot and bit, appears on `sd_o` one clock after that strobe, and `sd_oe` is 1 in tristate mode.
- R3: An output slot that is unassigned sends its idle byte MSB first with `sd_oe` = 1 when its idle-enable is 1, and keeps `sd_oe` = 0 for the whole slot when its idle-enable is 0.
- R4: During an input slot `sd_oe` is 0. `sd_i` is captured on each `rx_stb`, MSB first. The clock after the eighth capture, the byte is in that slot's receive buffer and the slot's valid flag is set.
- R5: With `od_mode` = 1, a 0 bit gives `sd_oe` = 1 and `sd_o` = 0, and a 1 bit gives `sd_oe` = 0. `sd_o` is never 1 while `sd_oe` = 1 in this mode.
- R6: With `standby` = 1, `sd_oe` is 0 in every slot. Holding registers are still consumed at their slot start, and input slots are still received.
- R7: A configuration write (`cfg_we`) takes effect at the next frame start, which is the `tx_stb` with slot 0 and bit 0. Slots later in the current frame keep the old settings.
- R8: `tx_ready` is 1 exactly when the holding register of `tx_slot` is empty. An accepted byte clears it until that slot starts as an assigned output. An assigned slot that starts with an empty holding register behaves as if it were unassigned.
- R9: `rx_valid` is 1 while any slot flag is set. `rx_slot` and `rx_data` present the lowest flagged slot, and a handshake clears that flag. `rx_valid` does not fall without a handshake. A newer byte overwrites an untaken one, and it wins over a clear in the same cycle.
- R10: Direction, assignment and idle behaviour are held separately per slot, so neighbouring slots in one frame can be data, idle, floating and input at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_stb | input | 1 | Presentation strobe for bit `pos_bit` of slot `pos_slot` |
| rx_stb | input | 1 | Sampling strobe, issued after `tx_stb` for the same bit |
| pos_slot | input | log2(NSLOT) | Current slot from the frame counter |
| pos_bit | input | 3 | Current bit in slot, 0 = MSB |
| cfg_we | input | 1 | Write strobe for slot configuration |
| cfg_slot | input | log2(NSLOT) | Slot being configured |
| cfg_in | input | 1 | 1 = input slot, 0 = output slot |
| cfg_asg | input | 1 | Output slot carries transmit data |
| cfg_idle_en | input | 1 | Unassigned output sends idle byte (1) or floats (0) |
| cfg_idle | input | 8 | Idle byte for the slot |
| od_mode | input | 1 | 1 = open-drain signalling, 0 = tristate |
| standby | input | 1 | Float the pin, keep internal operation |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Holding register of `tx_slot` is empty |
| tx_slot | input | log2(NSLOT) | Target slot of transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_ready | input | 1 | Consumer takes the presented byte |
| rx_slot | output | log2(NSLOT) | Slot of the presented byte |
| rx_data | output | 8 | Presented received byte |
| sd_i | input | 1 | Line value as seen at the pin |
| sd_o | output | 1 | Line drive value |
| sd_oe | output | 1 | Line driver enable |

## Verification
The bench builds the block with its default of eight slots of eight bits. With these values the preset puts four output slots against four input slots, and a single frame can place a data slot, an idle slot, a floating slot and an input slot side by side. Because slot 0 is the frame start, driving a partial frame and writing a configuration in the middle of it shows whether the write waits for the next frame. Whole frames run in tristate mode, open-drain mode and standby, and the receive buffer is left undrained across two frames so that overwriting with a newer byte and lowest-slot-first delivery can both be seen.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);

  typedef struct packed {
    logic              is_in;
    logic              assigned;
    logic              idle_en;
    logic [BYTE_W-1:0] idle;
  } slot_cfg_t;

  typedef enum logic [1:0] {
    SRC_FLOAT = 2'd0,
    SRC_IDLE  = 2'd1,
    SRC_DATA  = 2'd2,
    SRC_INPUT = 2'd3
  } slot_src_t;
endpackage

// File: rtl/sdp_cfg_bank.sv
module sdp_cfg_bank
  import sdp_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  slot_cfg_t         wcfg,
  input  logic              frame_start,
  output slot_cfg_t         cfg_now [NSLOT],
  output logic [NSLOT-1:0]  act_in
);
  slot_cfg_t pend [NSLOT];
  slot_cfg_t live [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic PRESET_IN = (i >= NSLOT / 2);

    // pending copy: written by software strobe at any time
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[i].is_in    <= PRESET_IN;
        pend[i].assigned <= 1'b0;
        pend[i].idle_en  <= 1'b0;
        pend[i].idle     <= '0;
      end else if (we && (wslot == SLOT_W'(i))) begin
        pend[i] <= wcfg;
      end
    end

    // live copy: follows pending only at frame start
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[i].is_in    <= PRESET_IN;
        live[i].assigned <= 1'b0;
        live[i].idle_en  <= 1'b0;
        live[i].idle     <= '0;
      end else if (frame_start) begin
        live[i] <= pend[i];
      end
    end

    // at the frame start edge the new settings already apply to slot 0
    assign cfg_now[i] = frame_start ? pend[i] : live[i];
    assign act_in[i]  = live[i].is_in;
  end
endmodule

// File: rtl/sdp_tx_lane.sv
module sdp_tx_lane
  import sdp_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_stb,
  input  logic [SLOT_W-1:0] pos_slot,
  input  logic [BIT_W-1:0]  pos_bit,
  input  slot_cfg_t         cfg_now [NSLOT],
  input  logic              od_mode,
  input  logic              standby,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sd_o,
  output logic              sd_oe
);
  logic [BYTE_W-1:0] hold [NSLOT];
  logic [NSLOT-1:0]  full;

  slot_cfg_t         c;
  slot_src_t         new_src, cur_src, sel_src;
  logic [BYTE_W-1:0] new_byte, cur_byte, sel_byte;
  logic [BIT_W-1:0]  bidx;
  logic              slot_start, take, consume;
  logic              drv_bit, drv_en;

  assign slot_start = tx_stb && (pos_bit == '0);
  assign tx_ready   = !full[tx_slot];
  assign take       = tx_valid && tx_ready;

  always_comb begin
    c = cfg_now[pos_slot];
    if (c.is_in)                             new_src = SRC_INPUT;
    else if (c.assigned && full[pos_slot])   new_src = SRC_DATA;
    else if (c.idle_en)                      new_src = SRC_IDLE;
    else                                     new_src = SRC_FLOAT;
    new_byte = (new_src == SRC_DATA) ? hold[pos_slot] : c.idle;
  end

  assign consume  = slot_start && (new_src == SRC_DATA);
  assign sel_src  = slot_start ? new_src  : cur_src;
  assign sel_byte = slot_start ? new_byte : cur_byte;
  assign bidx     = BIT_W'(BYTE_W - 1) - pos_bit;

  for (genvar i = 0; i < NSLOT; i++) begin : g_hold
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full[i] <= 1'b0;
        hold[i] <= '0;
      end else begin
        if (consume && (pos_slot == SLOT_W'(i))) full[i] <= 1'b0;
        if (take && (tx_slot == SLOT_W'(i))) begin
          full[i] <= 1'b1;
          hold[i] <= tx_data;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_src  <= SRC_FLOAT;
      cur_byte <= '0;
      drv_bit  <= 1'b0;
      drv_en   <= 1'b0;
    end else if (tx_stb) begin
      if (slot_start) begin
        cur_src  <= new_src;
        cur_byte <= new_byte;
      end
      drv_bit <= sel_byte[bidx];
      drv_en  <= (sel_src == SRC_DATA) || (sel_src == SRC_IDLE);
    end
  end

  // pin shaping: open-drain releases for 1, standby releases always
  assign sd_o  = od_mode ? 1'b0 : drv_bit;
  assign sd_oe = !standby && drv_en && (!od_mode || !drv_bit);
endmodule

// File: rtl/sdp_rx_lane.sv
module sdp_rx_lane
  import sdp_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_stb,
  input  logic [SLOT_W-1:0] pos_slot,
  input  logic [BIT_W-1:0]  pos_bit,
  input  logic [NSLOT-1:0]  act_in,
  input  logic              sd_i,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [BYTE_W-1:0] rx_data
);
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-1:0] rbuf [NSLOT];
  logic [NSLOT-1:0]  flag;
  logic              sample, commit, pop;
  logic [SLOT_W-1:0] pick;

  assign sample = rx_stb && act_in[pos_slot];
  assign commit = sample && (pos_bit == BIT_W'(BYTE_W - 1));
  assign pop    = rx_valid && rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (sample) sh <= {sh[BYTE_W-3:0], sd_i};
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag[i] <= 1'b0;
        rbuf[i] <= '0;
      end else begin
        if (pop && (pick == SLOT_W'(i))) flag[i] <= 1'b0;
        if (commit && (pos_slot == SLOT_W'(i))) begin
          flag[i] <= 1'b1;
          rbuf[i] <= {sh, sd_i};
        end
      end
    end
  end

  // lowest flagged slot is presented first
  always_comb begin
    pick = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (flag[i]) pick = SLOT_W'(i);
    end
  end

  assign rx_valid = |flag;
  assign rx_slot  = pick;
  assign rx_data  = rbuf[pick];
endmodule

// File: rtl/sdp_slot_port.sv
module sdp_slot_port
  import sdp_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_stb,
  input  logic              rx_stb,
  input  logic [SLOT_W-1:0] pos_slot,
  input  logic [BIT_W-1:0]  pos_bit,
  input  logic              cfg_we,
  input  logic [SLOT_W-1:0] cfg_slot,
  input  logic              cfg_in,
  input  logic              cfg_asg,
  input  logic              cfg_idle_en,
  input  logic [BYTE_W-1:0] cfg_idle,
  input  logic              od_mode,
  input  logic              standby,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe
);
  slot_cfg_t        wcfg;
  slot_cfg_t        cfg_now [NSLOT];
  logic [NSLOT-1:0] act_in;
  logic             frame_start;

  assign frame_start = tx_stb && (pos_slot == '0) && (pos_bit == '0);

  always_comb begin
    wcfg.is_in    = cfg_in;
    wcfg.assigned = cfg_asg;
    wcfg.idle_en  = cfg_idle_en;
    wcfg.idle     = cfg_idle;
  end

  sdp_cfg_bank #(.NSLOT(NSLOT)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (cfg_we),
    .wslot      (cfg_slot),
    .wcfg       (wcfg),
    .frame_start(frame_start),
    .cfg_now    (cfg_now),
    .act_in     (act_in)
  );

  sdp_tx_lane #(.NSLOT(NSLOT)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_stb  (tx_stb),
    .pos_slot(pos_slot),
    .pos_bit (pos_bit),
    .cfg_now (cfg_now),
    .od_mode (od_mode),
    .standby (standby),
    .tx_valid(tx_valid),
    .tx_ready(tx_ready),
    .tx_slot (tx_slot),
    .tx_data (tx_data),
    .sd_o    (sd_o),
    .sd_oe   (sd_oe)
  );

  sdp_rx_lane #(.NSLOT(NSLOT)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_stb  (rx_stb),
    .pos_slot(pos_slot),
    .pos_bit (pos_bit),
    .act_in  (act_in),
    .sd_i    (sd_i),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .rx_slot (rx_slot),
    .rx_data (rx_data)
  );
endmodule

// File: rtl/sdp_slot_port_chk.sv
module sdp_slot_port_chk
  import sdp_pkg::*;
#(
  parameter  int unsigned NSLOT  = 8,
  localparam int unsigned SLOT_W = $clog2(NSLOT)
) (
  input logic clk,
  input logic rst_n,
  input logic tx_stb,
  input logic od_mode,
  input logic standby,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_ready,
  input logic sd_o,
  input logic sd_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sd_oe && !rx_valid && tx_ready));

  assert_pin_moves_on_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tx_stb) && $stable(standby) && $stable(od_mode)) |-> ($stable(sd_oe) && $stable(sd_o)));

  assert_od_never_drives_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (od_mode && sd_oe) |-> !sd_o);

  assert_standby_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !sd_oe);

  assert_rx_held_until_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);
endmodule

bind sdp_slot_port sdp_slot_port_chk #(.NSLOT(NSLOT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tx_stb  (tx_stb),
  .od_mode (od_mode),
  .standby (standby),
  .rx_valid(rx_valid),
  .rx_ready(rx_ready),
  .tx_ready(tx_ready),
  .sd_o    (sd_o),
  .sd_oe   (sd_oe)
);

// File: tb/sdp_slot_port_tb.sv
module sdp_slot_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_stb = 0, rx_stb = 0;
  logic [2:0] pos_slot = 0;
  logic [2:0] pos_bit = 0;
  logic cfg_we = 0, cfg_in = 0, cfg_asg = 0, cfg_idle_en = 0;
  logic [2:0] cfg_slot = 0;
  logic [7:0] cfg_idle = 0;
  logic od_mode = 0, standby = 0;
  logic tx_valid = 0;
  logic tx_ready;
  logic [2:0] tx_slot = 0;
  logic [7:0] tx_data = 0;
  logic rx_valid;
  logic rx_ready = 0;
  logic [2:0] rx_slot;
  logic [7:0] rx_data;
  logic sd_i = 0;
  logic sd_o, sd_oe;

  logic [7:0] in_byte [NS];
  logic [7:0] obs_o   [NS];
  logic [7:0] obs_oe  [NS];
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdp_slot_port #(.NSLOT(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_stb(tx_stb), .rx_stb(rx_stb),
    .pos_slot(pos_slot), .pos_bit(pos_bit),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_in(cfg_in), .cfg_asg(cfg_asg),
    .cfg_idle_en(cfg_idle_en), .cfg_idle(cfg_idle),
    .od_mode(od_mode), .standby(standby),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_slot(tx_slot), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_slot(rx_slot), .rx_data(rx_data),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input int s, input bit in_, input bit asg, input bit ien, input logic [7:0] idl);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 3'(s); cfg_in = in_; cfg_asg = asg; cfg_idle_en = ien; cfg_idle = idl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic tx_push(input int s, input logic [7:0] d);
    @(negedge clk);
    tx_slot = 3'(s); tx_data = d; tx_valid = 1;
    chk("R8 ready before push", int'(tx_ready), 1);
    @(negedge clk);
    tx_valid = 0;
    chk("R8 ready drops after accept", int'(tx_ready), 0);
  endtask

  task automatic run_slots(input int s0, input int s1);
    for (int s = s0; s <= s1; s++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        rx_stb = 0;
        pos_slot = 3'(s); pos_bit = 3'(b);
        sd_i = in_byte[s][7-b];
        tx_stb = 1;
        @(negedge clk);
        tx_stb = 0;
        rx_stb = 1;
        obs_o[s][7-b]  = sd_o;
        obs_oe[s][7-b] = sd_oe;
      end
    end
    @(negedge clk);
    rx_stb = 0;
  endtask

  task automatic drain(input int lo, input string req);
    for (int s = lo; s < NS; s++) begin
      @(negedge clk);
      chk({req, " rx_valid"}, int'(rx_valid), 1);
      chk({req, " rx_slot lowest first"}, int'(rx_slot), s);
      chk({req, " rx_data"}, int'(rx_data), int'(in_byte[s]));
      rx_ready = 1;
      @(negedge clk);
      rx_ready = 0;
    end
    chk({req, " rx empty after drain"}, int'(rx_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 sd_oe reset", int'(sd_oe), 0);
    chk("R1 rx_valid reset", int'(rx_valid), 0);
    for (int s = 0; s < NS; s++) begin
      tx_slot = 3'(s);
      #1 chk("R1 tx_ready reset", int'(tx_ready), 1);
    end
    for (int s = 0; s < NS; s++) in_byte[s] = 8'(8'h11 * (s + 1));
    run_slots(0, 7);
    for (int s = 0; s < NS; s++) chk("R1 R4 preset slots released", int'(obs_oe[s]), 0);
    drain(4, "R1 R4 preset input slots");
  endtask

  task automatic t_mixed;
    cfg_write(0, 0, 1, 0, 8'h00);
    cfg_write(1, 0, 0, 1, 8'hA5);
    cfg_write(2, 0, 0, 0, 8'hFF);
    cfg_write(3, 1, 0, 0, 8'h00);
    in_byte[3] = 8'h96;
    tx_push(0, 8'h3C);
    run_slots(0, 7);
    chk("R2 data bits MSB first", int'(obs_o[0]), 'h3C);
    chk("R2 data enable", int'(obs_oe[0]), 'hFF);
    chk("R3 idle byte", int'(obs_o[1]), 'hA5);
    chk("R3 idle enable", int'(obs_oe[1]), 'hFF);
    chk("R3 R10 float slot", int'(obs_oe[2]), 0);
    chk("R4 R10 input slot released", int'(obs_oe[3]), 0);
    tx_slot = 0;
    #1 chk("R8 holding consumed", int'(tx_ready), 1);
    drain(3, "R4 R10 mixed frame");
  endtask

  task automatic t_underrun;
    run_slots(0, 7);
    chk("R8 empty assigned slot floats", int'(obs_oe[0]), 0);
    chk("R10 idle unaffected", int'(obs_o[1]), 'hA5);
    drain(3, "R8 underrun frame");
  endtask

  task automatic t_open_drain;
    od_mode = 1;
    tx_push(0, 8'h5A);
    run_slots(0, 7);
    chk("R5 od enable is inverted data", int'(obs_oe[0]), 'hA5);
    chk("R5 od drive value low", int'(obs_o[0]), 0);
    chk("R5 od idle enable", int'(obs_oe[1]), 'h5A);
    od_mode = 0;
    drain(3, "R5 od frame");
  endtask

  task automatic t_standby;
    standby = 1;
    tx_push(0, 8'hF0);
    in_byte[3] = 8'h3E;
    run_slots(0, 7);
    for (int s = 0; s < 3; s++) chk("R6 standby floats", int'(obs_oe[s]), 0);
    tx_slot = 0;
    #1 chk("R6 holding consumed in standby", int'(tx_ready), 1);
    standby = 0;
    drain(3, "R6 standby receive");
  endtask

  task automatic t_midframe_cfg;
    run_slots(0, 0);
    cfg_write(2, 0, 0, 1, 8'h42);
    run_slots(1, 7);
    chk("R7 old setting holds mid frame", int'(obs_oe[2]), 0);
    drain(3, "R7 frame a");
    run_slots(0, 7);
    chk("R7 new idle next frame", int'(obs_o[2]), 'h42);
    chk("R7 new enable next frame", int'(obs_oe[2]), 'hFF);
    drain(3, "R7 frame b");
  endtask

  task automatic t_overwrite;
    in_byte[3] = 8'h11;
    run_slots(0, 7);
    @(negedge clk);
    chk("R9 valid held without ready", int'(rx_valid), 1);
    in_byte[3] = 8'h77;
    run_slots(0, 7);
    drain(3, "R9 overwrite newest");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mixed();
    t_underrun();
    t_open_drain();
    t_standby();
    t_midframe_cfg();
    t_overwrite();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule